// File: doc/BRIEF.md
# Dual-Port Banked Data Memory Front End

This block sits between two load/store pipeline ports and a small on-chip data memory. The memory is split into two halves, chosen by the top address bit. Each half is interleaved across eight halfword-wide banks. Bit 3 of the address picks the even or odd doubleword group, and bits 2:1 pick the halfword lane within that group. Every cycle each port may present a request with a direction, an access size, a byte address and write data. The block checks alignment, works out which banks each access touches, and performs both accesses in the same cycle unless they touch a common bank in the same half.

When such a collision occurs, port A is performed at once and port B is held. A one-cycle stall is raised toward the pipeline, and port B is performed during that stall cycle. Both read results are then presented together. A misaligned request is dropped and reported on an error pulse and a sticky error flag for its port. Storage is a plain behavioural array that is not cleared by reset.

Top module: `dbank_arbiter`

## Requirements
- R1: Size codes are 0 byte, 1 halfword, 2 word and 3 doubleword. An access is aligned when its byte address is a multiple of its size. A byte access is always aligned.
- R2: A misaligned request is not performed and changes no memory byte. Its port's error output pulses high for one cycle, in the cycle after the request is accepted. Its sticky error flag goes high then and stays high until reset.
- R3: Two accepted aligned requests whose address top bits differ never stall, whatever their low address bits.
- R4: Two accepted aligned requests in the same half touch disjoint halfword banks when their sets of {addr[3], addr[2:1]} over the bytes they cover share no member. Such requests both complete with no stall. Read results appear in the next cycle with a one-cycle valid pulse.
- R5: When two accepted aligned requests in the same half share a halfword bank, stall is high for exactly the one cycle after the request. Port A is performed first and port B second. Both read valids pulse together in the cycle after the stall, and neither is high during it.
- R6: All request inputs are ignored while stall is high. No memory byte changes, no error pulses and no read result is produced for them.
- R7: Write data is right-justified. Only the bytes from the address up to address+size-1 are written.
- R8: Read data is right-justified and zero-extended above the access size. Its valid pulses only for reads.
- R9: Two doubleword accesses at offsets 0x00 and 0x10 conflict, and so do two at 0x08 and 0x18. Two at 0x00 and 0x08 do not conflict.
- R10: During and right after reset, stall, both read valids, both error pulses and both sticky flags are low.
- R11: When a conflict serializes a port A write and a port B read of overlapping bytes, port B returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Port A request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_size | input | 2 | Port A access size code |
| a_addr | input | ADDR_W | Port A byte address |
| a_wdata | input | 64 | Port A right-justified write data |
| b_req | input | 1 | Port B request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_size | input | 2 | Port B access size code |
| b_addr | input | ADDR_W | Port B byte address |
| b_wdata | input | 64 | Port B right-justified write data |
| stall | output | 1 | One-cycle stall after a bank conflict |
| a_rvalid | output | 1 | Port A read result valid |
| a_rdata | output | 64 | Port A right-justified read data |
| a_err | output | 1 | Port A misalignment pulse |
| a_err_sticky | output | 1 | Port A sticky misalignment flag |
| b_rvalid | output | 1 | Port B read result valid |
| b_rdata | output | 64 | Port B right-justified read data |
| b_err | output | 1 | Port B misalignment pulse |
| b_err_sticky | output | 1 | Port B sticky misalignment flag |

## Verification
A wrong bank mask or half select shows up one cycle after the request. Stall rises where the bench expects none, or stays low where the bench expects one, and the timing of the read valids shifts with it. A held port B request with corrupt state writes the wrong bytes or returns wrong data in the cycle after the stall. A write that lands in the wrong place or was never blocked stays in memory, so a later readback in the random phase exposes it, often hundreds of cycles after the fault. A stuck stall state stops all further results and is caught on the next request.

// File: rtl/dbank_pkg.sv
package dbank_pkg;

    localparam int DATA_W  = 64;
    localparam int LANES   = DATA_W / 8;
    localparam int HBANKS  = 2 * (LANES / 2);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic               we;
        logic [LANES-1:0]   be;
        logic [DATA_W-1:0]  wlane;
        logic [2:0]         off;
        acc_size_e          size;
    } held_op_t;

    function automatic logic size_aligned(acc_size_e sz, logic [2:0] off);
        case (sz)
            SZ_BYTE:  return 1'b1;
            SZ_HALF:  return ~off[0];
            SZ_WORD:  return off[1:0] == 2'b00;
            default:  return off == 3'b000;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_enables(acc_size_e sz, logic [2:0] off);
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE:  m = 8'h01;
            SZ_HALF:  m = 8'h03;
            SZ_WORD:  m = 8'h0F;
            default:  m = 8'hFF;
        endcase
        return m << off;
    endfunction

    function automatic logic [HBANKS-1:0] halfword_banks(logic [LANES-1:0] be, logic odd_dw);
        logic [LANES/2-1:0] hm;
        for (int i = 0; i < LANES / 2; i++) begin
            hm[i] = be[2*i] | be[2*i+1];
        end
        return odd_dw ? {hm, {(LANES/2){1'b0}}} : {{(LANES/2){1'b0}}, hm};
    endfunction

    function automatic logic [DATA_W-1:0] pick_read(logic [DATA_W-1:0] dw,
                                                    logic [2:0] off, acc_size_e sz);
        logic [DATA_W-1:0] s;
        logic [DATA_W-1:0] m;
        s = dw >> {off, 3'b000};
        case (sz)
            SZ_BYTE:  m = 64'h0000_0000_0000_00FF;
            SZ_HALF:  m = 64'h0000_0000_0000_FFFF;
            SZ_WORD:  m = 64'h0000_0000_FFFF_FFFF;
            default:  m = '1;
        endcase
        return s & m;
    endfunction

endpackage

// File: rtl/dbank_port_decode.sv
module dbank_port_decode
    import dbank_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  acc_size_e                  size,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic                       aligned,
    output logic [ADDR_W-4:0]          dw_addr,
    output logic [HBANKS-1:0]          banks,
    output logic [LANES-1:0]           be,
    output logic [DATA_W-1:0]          wlane
);
    logic [2:0] off;

    assign off     = addr[2:0];
    assign dw_addr = addr[ADDR_W-1:3];
    assign aligned = size_aligned(size, off);
    assign be      = lane_enables(size, off);
    assign banks   = halfword_banks(be, addr[3]);
    assign wlane   = wdata << {off, 3'b000};

    always_comb begin
        if (aligned) begin
            AST_LANE_COUNT: assert ($countones(be) == (1 << size)); // R7
        end
    end

endmodule

// File: rtl/dbank_conflict.sv
module dbank_conflict
    import dbank_pkg::*;
(
    input  logic              va,
    input  logic              vb,
    input  logic              half_a,
    input  logic              half_b,
    input  logic [HBANKS-1:0] banks_a,
    input  logic [HBANKS-1:0] banks_b,
    output logic              conflict
);
    logic same_half;
    logic overlap;

    assign same_half = half_a == half_b;
    assign overlap   = |(banks_a & banks_b);
    assign conflict  = va & vb & same_half & overlap;

endmodule

// File: rtl/dbank_storage.sv
module dbank_storage
    import dbank_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                   clk,
    input  logic                   w0_en,
    input  logic [ADDR_W-4:0]      w0_addr,
    input  logic [LANES-1:0]       w0_be,
    input  logic [DATA_W-1:0]      w0_data,
    input  logic                   w1_en,
    input  logic [ADDR_W-4:0]      w1_addr,
    input  logic [LANES-1:0]       w1_be,
    input  logic [DATA_W-1:0]      w1_data,
    input  logic [ADDR_W-4:0]      r0_addr,
    input  logic [ADDR_W-4:0]      r1_addr,
    output logic [DATA_W-1:0]      r0_data,
    output logic [DATA_W-1:0]      r1_data
);
    localparam int DEPTH = 2 ** (ADDR_W - 3);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < LANES; b++) begin
            if (w0_en && w0_be[b]) mem[w0_addr][b*8 +: 8] <= w0_data[b*8 +: 8];
            if (w1_en && w1_be[b]) mem[w1_addr][b*8 +: 8] <= w1_data[b*8 +: 8];
        end
    end

    assign r0_data = mem[r0_addr];
    assign r1_data = mem[r1_addr];

endmodule

// File: rtl/dbank_arbiter.sv
module dbank_arbiter
    import dbank_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               a_req,
    input  logic               a_we,
    input  logic [1:0]         a_size,
    input  logic [ADDR_W-1:0]  a_addr,
    input  logic [63:0]        a_wdata,
    input  logic               b_req,
    input  logic               b_we,
    input  logic [1:0]         b_size,
    input  logic [ADDR_W-1:0]  b_addr,
    input  logic [63:0]        b_wdata,
    output logic               stall,
    output logic               a_rvalid,
    output logic [63:0]        a_rdata,
    output logic               a_err,
    output logic               a_err_sticky,
    output logic               b_rvalid,
    output logic [63:0]        b_rdata,
    output logic               b_err,
    output logic               b_err_sticky
);
    localparam int DWA_W = ADDR_W - 3;
    localparam int NPORT = 2;

    logic [NPORT-1:0]   req_v, we_v, alg, v;
    acc_size_e          size_v  [NPORT];
    logic [ADDR_W-1:0]  addr_v  [NPORT];
    logic [DATA_W-1:0]  wd_v    [NPORT];
    logic [DWA_W-1:0]   dwa     [NPORT];
    logic [HBANKS-1:0]  banks   [NPORT];
    logic [LANES-1:0]   be      [NPORT];
    logic [DATA_W-1:0]  wl      [NPORT];

    assign req_v     = {b_req, a_req};
    assign we_v      = {b_we, a_we};
    assign size_v[0] = acc_size_e'(a_size);
    assign size_v[1] = acc_size_e'(b_size);
    assign addr_v[0] = a_addr;
    assign addr_v[1] = b_addr;
    assign wd_v[0]   = a_wdata;
    assign wd_v[1]   = b_wdata;

    logic stall_q;
    logic accept;
    logic conflict;

    assign accept = ~stall_q;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dbank_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .size    (size_v[p]),
            .addr    (addr_v[p]),
            .wdata   (wd_v[p]),
            .aligned (alg[p]),
            .dw_addr (dwa[p]),
            .banks   (banks[p]),
            .be      (be[p]),
            .wlane   (wl[p])
        );
        assign v[p] = accept & req_v[p] & alg[p];
    end

    dbank_conflict u_cf (
        .va       (v[0]),
        .vb       (v[1]),
        .half_a   (dwa[0][DWA_W-1]),
        .half_b   (dwa[1][DWA_W-1]),
        .banks_a  (banks[0]),
        .banks_b  (banks[1]),
        .conflict (conflict)
    );

    // Port B request parked for the stall cycle
    held_op_t          hb_op;
    logic [DWA_W-1:0]  hb_dwa;
    logic              a_pend_rd;

    logic              p1_wen;
    logic [DWA_W-1:0]  p1_dwa;
    logic [LANES-1:0]  p1_be;
    logic [DATA_W-1:0] p1_wl;
    logic [DATA_W-1:0] rd0, rd1;

    always_comb begin
        if (stall_q) begin
            p1_wen = hb_op.we;
            p1_dwa = hb_dwa;
            p1_be  = hb_op.be;
            p1_wl  = hb_op.wlane;
        end else begin
            p1_wen = v[1] & we_v[1] & ~conflict;
            p1_dwa = dwa[1];
            p1_be  = be[1];
            p1_wl  = wl[1];
        end
    end

    dbank_storage #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .w0_en   (v[0] & we_v[0]),
        .w0_addr (dwa[0]),
        .w0_be   (be[0]),
        .w0_data (wl[0]),
        .w1_en   (p1_wen),
        .w1_addr (p1_dwa),
        .w1_be   (p1_be),
        .w1_data (p1_wl),
        .r0_addr (dwa[0]),
        .r1_addr (p1_dwa),
        .r0_data (rd0),
        .r1_data (rd1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q      <= 1'b0;
            a_rvalid     <= 1'b0;
            b_rvalid     <= 1'b0;
            a_rdata      <= '0;
            b_rdata      <= '0;
            a_err        <= 1'b0;
            b_err        <= 1'b0;
            a_err_sticky <= 1'b0;
            b_err_sticky <= 1'b0;
            a_pend_rd    <= 1'b0;
            hb_op        <= '0;
            hb_dwa       <= '0;
        end else begin
            stall_q      <= conflict;
            a_err        <= accept & a_req & ~alg[0];
            b_err        <= accept & b_req & ~alg[1];
            a_err_sticky <= a_err_sticky | (accept & a_req & ~alg[0]);
            b_err_sticky <= b_err_sticky | (accept & b_req & ~alg[1]);

            if (v[0] && !we_v[0]) a_rdata <= pick_read(rd0, addr_v[0][2:0], size_v[0]);
            a_pend_rd <= v[0] & ~we_v[0] & conflict;
            a_rvalid  <= (v[0] & ~we_v[0] & ~conflict) | (stall_q & a_pend_rd);

            if (stall_q) begin
                if (!hb_op.we) b_rdata <= pick_read(rd1, hb_op.off, hb_op.size);
                b_rvalid <= ~hb_op.we;
            end else begin
                if (v[1] && !we_v[1] && !conflict)
                    b_rdata <= pick_read(rd1, addr_v[1][2:0], size_v[1]);
                b_rvalid <= v[1] & ~we_v[1] & ~conflict;
            end

            if (conflict) begin
                hb_op.we    <= we_v[1];
                hb_op.be    <= be[1];
                hb_op.wlane <= wl[1];
                hb_op.off   <= addr_v[1][2:0];
                hb_op.size  <= size_v[1];
                hb_dwa      <= dwa[1];
            end
        end
    end

    assign stall = stall_q;

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stall_q |=> !stall_q); // R5
    AST_CONFLICT_STALLS: assert property (@(posedge clk) disable iff (rst)
        conflict |=> stall_q); // R5
    AST_NO_RESULT_IN_STALL: assert property (@(posedge clk) disable iff (rst)
        stall_q |-> (!a_rvalid && !b_rvalid)); // R5
    AST_CROSS_HALF_FREE: assert property (@(posedge clk) disable iff (rst)
        (v[0] && v[1] && (dwa[0][DWA_W-1] != dwa[1][DWA_W-1])) |=> !stall_q); // R3
    AST_IGNORED_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        stall_q |=> (!a_err && !b_err)); // R6
    AST_STICKY_A_HOLDS: assert property (@(posedge clk) disable iff (rst)
        a_err_sticky |=> a_err_sticky); // R2
    AST_STICKY_B_HOLDS: assert property (@(posedge clk) disable iff (rst)
        b_err_sticky |=> b_err_sticky); // R2

endmodule

// File: tb/dbank_arbiter_tb.sv
`timescale 1ns/1ps
module dbank_arbiter_tb;
    localparam int AW = 10;
    localparam int NBYTES = 2 ** AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_req = 0, a_we = 0, b_req = 0, b_we = 0;
    logic [1:0] a_size = 0, b_size = 0;
    logic [AW-1:0] a_addr = 0, b_addr = 0;
    logic [63:0] a_wdata = 0, b_wdata = 0;
    logic stall, a_rvalid, b_rvalid, a_err, b_err, a_err_sticky, b_err_sticky;
    logic [63:0] a_rdata, b_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit poke = 0;
    logic [7:0] ref_mem [NBYTES];

    always #4 clk = ~clk;

    dbank_arbiter #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .a_req(a_req), .a_we(a_we), .a_size(a_size), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_req(b_req), .b_we(b_we), .b_size(b_size), .b_addr(b_addr), .b_wdata(b_wdata),
        .stall(stall),
        .a_rvalid(a_rvalid), .a_rdata(a_rdata), .a_err(a_err), .a_err_sticky(a_err_sticky),
        .b_rvalid(b_rvalid), .b_rdata(b_rdata), .b_err(b_err), .b_err_sticky(b_err_sticky)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit f_aligned(input logic [1:0] sz, input logic [AW-1:0] ad);
        int n = 1 << sz;
        return (int'(ad) % n) == 0;
    endfunction

    function automatic logic [7:0] f_banks(input logic [1:0] sz, input logic [AW-1:0] ad);
        logic [7:0] m = '0;
        for (int i = 0; i < (1 << sz); i++) begin
            logic [AW-1:0] x = ad + AW'(i);
            m[{x[3], x[2:1]}] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] f_read(input logic [1:0] sz, input logic [AW-1:0] ad);
        logic [63:0] r = '0;
        for (int i = 0; i < (1 << sz); i++) r[i*8 +: 8] = ref_mem[ad + AW'(i)];
        return r;
    endfunction

    task automatic f_write(input logic [1:0] sz, input logic [AW-1:0] ad, input logic [63:0] d);
        for (int i = 0; i < (1 << sz); i++) ref_mem[ad + AW'(i)] = d[i*8 +: 8];
    endtask

    task automatic do_pair(
        input logic ra, input logic wa, input logic [1:0] sa, input logic [AW-1:0] aa, input logic [63:0] da,
        input logic rb, input logic wb, input logic [1:0] sb, input logic [AW-1:0] ab, input logic [63:0] db);
        bit oka, okb, conf;
        logic [63:0] ea, eb;
        @(negedge clk);
        a_req = ra; a_we = wa; a_size = sa; a_addr = aa; a_wdata = da;
        b_req = rb; b_we = wb; b_size = sb; b_addr = ab; b_wdata = db;
        oka  = ra && f_aligned(sa, aa);
        okb  = rb && f_aligned(sb, ab);
        conf = oka && okb && (aa[AW-1] == ab[AW-1]) && ((f_banks(sa, aa) & f_banks(sb, ab)) != 0);
        ea = f_read(sa, aa);
        if (oka && wa) f_write(sa, aa, da);
        eb = f_read(sb, ab);
        if (okb && wb) f_write(sb, ab, db);
        @(negedge clk);
        if (conf && poke) begin
            a_req = 1; a_we = 1; a_size = 2'd3; a_addr = AW'('h40); a_wdata = 64'hDEAD_BEEF_0BAD_F00D;
            b_req = 1; b_we = 0; b_size = 2'd2; b_addr = AW'('h43);
        end else begin
            a_req = 0; b_req = 0;
        end
        chk(stall == conf, "R4/R5 stall after request", 64'(stall), 64'(conf));
        chk(a_err == (ra && !oka), "R2 port A error pulse", 64'(a_err), 64'(ra && !oka));
        chk(b_err == (rb && !okb), "R2 port B error pulse", 64'(b_err), 64'(rb && !okb));
        if (ra && !oka) chk(a_err_sticky, "R2 port A sticky", 64'(a_err_sticky), 64'd1);
        if (rb && !okb) chk(b_err_sticky, "R2 port B sticky", 64'(b_err_sticky), 64'd1);
        if (!conf) begin
            chk(a_rvalid == (oka && !wa), "R8 port A valid", 64'(a_rvalid), 64'(oka && !wa));
            chk(b_rvalid == (okb && !wb), "R8 port B valid", 64'(b_rvalid), 64'(okb && !wb));
        end else begin
            chk(!a_rvalid && !b_rvalid, "R5 no valid during stall", 64'({a_rvalid, b_rvalid}), 64'd0);
            @(negedge clk);
            a_req = 0; b_req = 0;
            chk(!stall, "R5 stall one cycle", 64'(stall), 64'd0);
            chk(!a_err && !b_err, "R6 no error for ignored inputs", 64'({a_err, b_err}), 64'd0);
            chk(a_rvalid == !wa, "R5 port A valid after stall", 64'(a_rvalid), 64'(!wa));
            chk(b_rvalid == !wb, "R5 port B valid after stall", 64'(b_rvalid), 64'(!wb));
        end
        if (oka && !wa) chk(a_rdata == ea, "R8 port A read data", a_rdata, ea);
        if (okb && !wb) chk(b_rdata == eb, "R8/R11 port B read data", b_rdata, eb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R5 actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!stall && !a_rvalid && !b_rvalid && !a_err && !b_err && !a_err_sticky && !b_err_sticky,
            "R10 outputs low in reset", 64'({stall, a_rvalid, b_rvalid, a_err, b_err}), 64'd0);
        rst = 0;
        @(negedge clk);
        chk(!stall && !a_err_sticky && !b_err_sticky, "R10 outputs low after reset",
            64'({stall, a_err_sticky, b_err_sticky}), 64'd0);

        // fill both halves, one half per port: R3
        for (int i = 0; i < NBYTES / 16; i++) begin
            do_pair(1, 1, 2'd3, AW'(i * 8), {$urandom, $urandom},
                    1, 1, 2'd3, AW'(NBYTES / 2 + i * 8), {$urandom, $urandom});
        end

        // R9 even/odd doubleword groups
        do_pair(1, 0, 2'd3, AW'('h00), 0, 1, 0, 2'd3, AW'('h10), 0);
        do_pair(1, 0, 2'd3, AW'('h08), 0, 1, 0, 2'd3, AW'('h18), 0);
        do_pair(1, 0, 2'd3, AW'('h00), 0, 1, 0, 2'd3, AW'('h08), 0);
        // R3 same bank index, other half
        do_pair(1, 0, 2'd3, AW'('h00), 0, 1, 0, 2'd3, AW'(NBYTES / 2), 0);
        // R4 word lanes disjoint inside one doubleword group
        do_pair(1, 1, 2'd2, AW'('h20), 64'h1122_3344, 1, 0, 2'd2, AW'('h24), 0);
        // R11 serialized write then read
        do_pair(1, 1, 2'd2, AW'('h30), 64'hCAFE_F00D, 1, 0, 2'd3, AW'('h30), 0);
        // R1 / R2 alignment cases
        do_pair(1, 0, 2'd2, AW'('h22), 0, 1, 0, 2'd1, AW'('h51), 0);
        do_pair(1, 0, 2'd0, AW'('h33), 0, 1, 1, 2'd3, AW'('h64), 64'hFFFF);
        do_pair(1, 0, 2'd3, AW'('h60), 0, 0, 0, 2'd0, 0, 0);
        // R7 byte write then wide readback
        do_pair(1, 1, 2'd0, AW'('h45), 64'hABCD_EFA5, 0, 0, 2'd0, 0, 0);
        do_pair(1, 0, 2'd3, AW'('h40), 0, 0, 0, 2'd0, 0, 0);
        // R6 inputs during stall are dropped
        poke = 1;
        do_pair(1, 0, 2'd1, AW'('h80), 0, 1, 0, 2'd0, AW'('h81), 0);
        poke = 0;
        do_pair(1, 0, 2'd3, AW'('h40), 0, 0, 0, 2'd0, 0, 0);

        // random phase
        for (int n = 0; n < 2000; n++) begin
            logic [1:0] sa = 2'($urandom_range(0, 3));
            logic [1:0] sb = 2'($urandom_range(0, 3));
            logic [AW-1:0] aa = AW'(($urandom_range(0, 1) << (AW - 1)) | $urandom_range(0, 63));
            logic [AW-1:0] ab = AW'(($urandom_range(0, 1) << (AW - 1)) | $urandom_range(0, 63));
            aa = aa & ~AW'((1 << sa) - 1);
            ab = ab & ~AW'((1 << sb) - 1);
            if (sa != 0 && $urandom_range(0, 9) == 0) aa = aa | AW'(1);
            if (sb != 0 && $urandom_range(0, 9) == 0) ab = ab | AW'(1);
            do_pair(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)), sa, aa, {$urandom, $urandom},
                    1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)), sb, ab, {$urandom, $urandom});
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule